// File: doc/BRIEF.md
# Timer Interrupt Flag Bank

This block keeps the pending-event flags of an eight-channel capture/compare timer together with one flag for counter wrap-around. Each channel owns one flag, which is set by an event pulse coming from that channel's capture or compare logic. A separate pulse from the counter sets the wrap flag. The counter, the prescaler and the capture/compare datapaths sit outside this block. Only their event pulses and their register addresses reach it.

Software sees the flags through a byte-wide register bus that carries one strobe per access. A flag is normally cleared by writing a one to its bit position, and this is only accepted while the timer or the pulse accumulator is switched on. When the fast-clear control input is high, flags also clear as a side effect of ordinary traffic. Reading a capture channel's data register clears that channel's flag, writing a compare channel's data register clears that channel's flag, and any access to the counter register clears the wrap flag. Each flag drives a registered interrupt line that is gated by its own enable bit.

Top module: `tmr_flag_bank`

## Requirements
- R1: After synchronous reset, all channel flags, the wrap flag, every interrupt output and the read data are zero.
- R2: A read of offset 0x0E returns the channel flags, with channel i in bit i. A read of offset 0x0F returns the wrap flag in bit 7 and zero in bits 6..0. Reads of any other offset return zero. Read data is registered and appears in the cycle after the read strobe.
- R3: A pulse on channel i's event input sets channel flag i. A pulse on the wrap event input sets the wrap flag.
- R4: A write to 0x0E clears every channel flag whose data bit is 1 and leaves the flags with 0 bits unchanged. A write to 0x0F clears the wrap flag only when data bit 7 is 1.
- R5: A write-one clear (R4) takes effect only while tmr_en or acc_en is high. When both are low, the write changes no flag.
- R6: When a set event and a clear of any kind reach the same flag in the same cycle, the flag ends up set.
- R7: With fast_clr high, an access to offset 0x10+2i or 0x11+2i clears channel flag i. The access must be a read when ch_mode[i]=0 (capture) and a write when ch_mode[i]=1 (compare). The other access kind leaves the flag alone. This clear does not depend on tmr_en or acc_en. With fast_clr low, these accesses clear nothing.
- R8: With fast_clr high, any read or write of counter offset 0x04 or 0x05 clears the wrap flag. With fast_clr low, such accesses leave it set.
- R9: ch_irq[i] equals channel flag i ANDed with irq_en[i], and ovf_irq equals the wrap flag ANDed with ovf_irq_en. Both are registered one cycle behind the flag and enable values.
- R10: A clear caused by a bus access takes effect on the clock edge that samples the strobe. A read of a flag register returns the flag values as they were before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr_en | input | 1 | Timer enabled |
| acc_en | input | 1 | Pulse accumulator enabled |
| fast_clr | input | 1 | Fast-clear mode |
| ch_mode | input | 8 | Per channel: 1 = compare, 0 = capture |
| ch_evt | input | 8 | Per channel capture/compare event pulse |
| ovf_evt | input | 1 | Counter wrap event pulse |
| irq_en | input | 8 | Channel interrupt enables |
| ovf_irq_en | input | 1 | Wrap interrupt enable |
| ch_irq | output | 8 | Channel interrupt outputs |
| ovf_irq | output | 1 | Wrap interrupt output |

## Verification
Flags change on the edge that samples an event or an access strobe. Read data from that access is due one cycle later, and an interrupt line follows its flag or enable one cycle after the flag or enable changes. The bench drives every input on the falling edge. It samples read data on the falling edge that follows the strobe, and it samples interrupt lines one full cycle after the stimulus. Each expected value therefore lands exactly in the cycle where the register chain puts it. The fast-clear rules are swept over every channel, both bytes of each channel register, and both access kinds, with a mixed capture/compare mode vector. Write-one clears are swept over all 256 data patterns, and the interrupt gating is swept over all 256 enable masks.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  localparam int OFS_CH_FLAGS = 'h0E;
  localparam int OFS_OVF_FLAG = 'h0F;
  localparam int OFS_CNT_HI   = 'h04;
  localparam int OFS_CNT_LO   = 'h05;
  localparam int OFS_CH_BASE  = 'h10;
endpackage

// File: rtl/tfr_bus_decode.sv
module tfr_bus_decode
  import tfr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NUM_CH-1:0] wdata_ch,
  input  logic              wdata_ovf,
  input  logic              clr_allow,
  input  logic              fast_clr,
  input  logic [NUM_CH-1:0] ch_mode,
  output logic [NUM_CH-1:0] ch_clr,
  output logic              ovf_clr,
  output logic              rd_ch_flags,
  output logic              rd_ovf_flag
);
  localparam logic [ADDR_W-1:0] A_CH  = ADDR_W'(OFS_CH_FLAGS);
  localparam logic [ADDR_W-1:0] A_OVF = ADDR_W'(OFS_OVF_FLAG);
  localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'(OFS_CNT_HI);
  localparam logic [ADDR_W-1:0] A_CLO = ADDR_W'(OFS_CNT_LO);

  logic wr_ch, wr_ovf, cnt_hit, rd_acc;
  logic [NUM_CH-1:0] fast_ch;

  assign rd_acc      = bus_sel && !bus_wr;
  assign wr_ch       = bus_sel && bus_wr && (bus_addr == A_CH) && clr_allow;
  assign wr_ovf      = bus_sel && bus_wr && (bus_addr == A_OVF) && clr_allow;
  assign cnt_hit     = bus_sel && fast_clr && ((bus_addr == A_CHI) || (bus_addr == A_CLO));
  assign rd_ch_flags = rd_acc && (bus_addr == A_CH);
  assign rd_ovf_flag = rd_acc && (bus_addr == A_OVF);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_fast
    localparam logic [ADDR_W-2:0] PAIR = (ADDR_W-1)'(OFS_CH_BASE / 2 + i);
    logic hit;
    assign hit = bus_sel && fast_clr && (bus_addr[ADDR_W-1:1] == PAIR);
    assign fast_ch[i] = hit && (bus_wr == ch_mode[i]);
  end

  assign ch_clr  = ({NUM_CH{wr_ch}} & wdata_ch) | fast_ch;
  assign ovf_clr = (wr_ovf && wdata_ovf) || cnt_hit;
endmodule

// File: rtl/tfr_flag_cell.sv
module tfr_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_req,
  input  logic irq_enable,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= set_evt | (flag & ~clr_req);
      irq  <= flag & irq_enable;
    end
  end
endmodule

// File: rtl/tfr_read_port.sv
module tfr_read_port #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ch_flags,
  input  logic              rd_ovf_flag,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [NUM_CH-1:0] ch_flags,
  input  logic              ovf_flag,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (bus_sel && !bus_wr) begin
      if (rd_ch_flags)      rdata <= DATA_W'(ch_flags);
      else if (rd_ovf_flag) rdata <= {ovf_flag, {(DATA_W-1){1'b0}}};
      else                  rdata <= '0;
    end
  end
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmr_en,
  input  logic              acc_en,
  input  logic              fast_clr,
  input  logic [NUM_CH-1:0] ch_mode,
  input  logic [NUM_CH-1:0] ch_evt,
  input  logic              ovf_evt,
  input  logic [NUM_CH-1:0] irq_en,
  input  logic              ovf_irq_en,
  output logic [NUM_CH-1:0] ch_irq,
  output logic              ovf_irq
);
  localparam int OVF_BIT = DATA_W - 1;

  logic [NUM_CH-1:0] ch_clr, ch_flag_q;
  logic ovf_clr, ovf_flag_q, rd_ch_flags, rd_ovf_flag;

  tfr_bus_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wdata_ch   (bus_wdata[NUM_CH-1:0]),
    .wdata_ovf  (bus_wdata[OVF_BIT]),
    .clr_allow  (tmr_en | acc_en),
    .fast_clr   (fast_clr),
    .ch_mode    (ch_mode),
    .ch_clr     (ch_clr),
    .ovf_clr    (ovf_clr),
    .rd_ch_flags(rd_ch_flags),
    .rd_ovf_flag(rd_ovf_flag)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tfr_flag_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .set_evt   (ch_evt[i]),
      .clr_req   (ch_clr[i]),
      .irq_enable(irq_en[i]),
      .flag      (ch_flag_q[i]),
      .irq       (ch_irq[i])
    );
  end

  tfr_flag_cell u_ovf (
    .clk       (clk),
    .rst       (rst),
    .set_evt   (ovf_evt),
    .clr_req   (ovf_clr),
    .irq_enable(ovf_irq_en),
    .flag      (ovf_flag_q),
    .irq       (ovf_irq)
  );

  tfr_read_port #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_ch_flags(rd_ch_flags),
    .rd_ovf_flag(rd_ovf_flag),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .ch_flags   (ch_flag_q),
    .ovf_flag   (ovf_flag_q),
    .rdata      (bus_rdata)
  );
endmodule

// File: rtl/tfr_checker.sv
module tfr_checker #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tmr_en,
  input logic              acc_en,
  input logic              fast_clr,
  input logic [NUM_CH-1:0] ch_evt,
  input logic              ovf_evt,
  input logic [NUM_CH-1:0] irq_en,
  input logic [NUM_CH-1:0] ch_flags,
  input logic              ovf_flag,
  input logic [NUM_CH-1:0] ch_irq
);
  a_r1_reset_clear: assert property (@(posedge clk)
    $fell(rst) |-> (ch_flags == '0 && !ovf_flag && ch_irq == '0 && bus_rdata == '0));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'('h0F)) |=> (bus_rdata[DATA_W-2:0] == '0));

  a_r3_ovf_sets: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf_flag);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ch_flags & $past(ch_evt)) == $past(ch_evt)));

  a_r5_no_clear_when_off: assert property (@(posedge clk) disable iff (rst)
    (!tmr_en && !acc_en && !fast_clr) |=> ((ch_flags & $past(ch_flags)) == $past(ch_flags)));

  a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ch_irq == ($past(ch_flags) & $past(irq_en))));
endmodule

bind tmr_flag_bank tfr_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .tmr_en(tmr_en), .acc_en(acc_en), .fast_clr(fast_clr),
  .ch_evt(ch_evt), .ovf_evt(ovf_evt), .irq_en(irq_en), .ch_flags(ch_flag_q),
  .ovf_flag(ovf_flag_q), .ch_irq(ch_irq)
);

// File: tb/tb_tmr_flag_bank.sv
module tb_tmr_flag_bank;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic tmr_en = 0, acc_en = 0, fast_clr = 0, ovf_evt = 0, ovf_irq_en = 0, ovf_irq;
  logic [7:0] ch_mode = '0, ch_evt = '0, irq_en = '0, ch_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_flag_bank dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic pulse(input logic [7:0] ce, input logic oe);
    @(negedge clk); ch_evt = ce; ovf_evt = oe;
    @(negedge clk); ch_evt = '0; ovf_evt = 0;
  endtask

  task automatic clear_all();
    logic t, a;
    t = tmr_en; a = acc_en; tmr_en = 1;
    wr(5'h0E, 8'hFF); wr(5'h0F, 8'h80);
    tmr_en = t; acc_en = a;
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", ch_irq, 8'h00);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    rst = 0;
    rd(5'h0E, d); check("R1 channel flags reset", d, 8'h00);
    rd(5'h0F, d); check("R1 wrap flag reset", d, 8'h00);

    // R3: each channel event sets its own flag, cumulatively
    exp = '0;
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i), 0);
      exp |= 8'(1 << i);
      rd(5'h0E, d); check("R3 channel set", d, exp);
    end
    pulse(8'h00, 1);
    rd(5'h0F, d); check("R2 R3 wrap flag bit7 only", d, 8'h80);
    rd(5'h03, d); check("R2 unmapped offset reads zero", d, 8'h00);

    // R5: write-one clear ignored with both enables low
    wr(5'h0E, 8'hFF); rd(5'h0E, d); check("R5 gated channel clear", d, 8'hFF);
    wr(5'h0F, 8'h80); rd(5'h0F, d); check("R5 gated wrap clear", d, 8'h80);

    // R4 R5: all write patterns, alternating enable source
    for (int p = 0; p < 256; p++) begin
      tmr_en = p[0]; acc_en = ~p[0];
      pulse(8'hFF, 0);
      wr(5'h0E, 8'(p));
      rd(5'h0E, d); check("R4 R5 write-one clear pattern", d, ~8'(p));
    end
    wr(5'h0F, 8'h7F); rd(5'h0F, d); check("R4 wrap clear ignores low bits", d, 8'h80);
    wr(5'h0F, 8'h80); rd(5'h0F, d); check("R4 wrap clear bit7", d, 8'h00);

    // R6: set and write-one clear in the same cycle
    tmr_en = 1; clear_all();
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 5'h0E; bus_wdata = 8'h08; ch_evt = 8'h08;
    @(negedge clk); bus_sel = 0; bus_wr = 0; ch_evt = '0;
    rd(5'h0E, d); check("R6 set wins over write clear", d, 8'h08);

    // R10: read in same cycle as event returns pre-edge value
    clear_all();
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 5'h0E; ch_evt = 8'h04;
    @(negedge clk); bus_sel = 0; ch_evt = '0; d = bus_rdata;
    check("R10 read returns pre-edge flags", d, 8'h00);
    rd(5'h0E, d); check("R10 flag visible on next read", d, 8'h04);

    // R7: fast clear sweep, enables off, mixed modes
    tmr_en = 0; acc_en = 0; fast_clr = 1; ch_mode = 8'hA6;
    for (int ch = 0; ch < 8; ch++)
      for (int b = 0; b < 2; b++)
        for (int op = 0; op < 2; op++) begin
          pulse(8'hFF, 0);
          if (op == 1) wr(5'(16 + 2*ch + b), 8'h00);
          else         rd(5'(16 + 2*ch + b), d);
          exp = ((op == 1) == ch_mode[ch]) ? ~8'(1 << ch) : 8'hFF;
          rd(5'h0E, d); check("R7 fast clear by channel access", d, exp);
        end
    // R6: fast clear racing an event on the same channel
    pulse(8'hFF, 0);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 5'h10; ch_evt = 8'h01;
    @(negedge clk); bus_sel = 0; ch_evt = '0;
    rd(5'h0E, d); check("R6 set wins over fast clear", d, 8'hFF);
    fast_clr = 0;
    for (int ch = 0; ch < 8; ch++) begin
      rd(5'(16 + 2*ch), d); wr(5'(17 + 2*ch), 8'h00);
    end
    rd(5'h0E, d); check("R7 no fast clear when mode off", d, 8'hFF);

    // R8: counter access clears wrap flag only in fast-clear mode
    pulse(8'h00, 1);
    rd(5'h04, d); wr(5'h05, 8'h12);
    rd(5'h0F, d); check("R8 counter access without fast clear", d, 8'h80);
    fast_clr = 1;
    rd(5'h04, d); rd(5'h0F, d); check("R8 counter read clears wrap", d, 8'h00);
    pulse(8'h00, 1);
    wr(5'h05, 8'h00); rd(5'h0F, d); check("R8 counter write clears wrap", d, 8'h00);
    fast_clr = 0;

    // R9: interrupt gating over every enable mask
    tmr_en = 1; clear_all();
    pulse(8'hA5, 1);
    @(negedge clk);
    for (int e = 0; e < 256; e++) begin
      @(negedge clk); irq_en = 8'(e); ovf_irq_en = e[0];
      @(negedge clk);
      check("R9 channel irq gating", ch_irq, 8'hA5 & 8'(e));
      check("R9 wrap irq gating", {7'b0, ovf_irq}, {7'b0, e[0]});
    end
    // R9: irq drops one cycle after the flag clears
    wr(5'h0E, 8'h05);
    @(negedge clk);
    check("R9 irq follows cleared flags", ch_irq, 8'hA0 & irq_en);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule